// File: doc/BRIEF.md
# Serial Port Baud and Bit-Clock Generator

This block turns the system clock into the two timing strobes a serial port needs: a receive base strobe at the programmed baud-generator rate and a transmit strobe at the bit rate. A 12-bit reload down-counter, clocked by the system clock, produces one base strobe each time it reaches zero. A divider chain made of a /2 stage, a /4 stage and a /2 stage slows that strobe for transmission. Mode inputs choose the tap. A synchronous slave mode bypasses the chain: the transmit strobe then comes from edges of an external serial clock, after that clock has been synchronised.

Software loads the divisor in two parts. Writing the 4-bit upper part only stages the value. Writing the 8-bit lower part restarts the counter at once with the combined value. In synchronous master mode the first divider stage drives the serial clock output.

Top module: `usart_clkgen`

## Requirements
- R1: While reset is held (synchronous, active low) all three outputs are 0. Reset clears the divisor, the counter, every divider stage and the external-clock synchroniser.
- R2: With no divisor write, `rx_tick` pulses for one cycle every divisor+1 cycles. It first pulses in the first cycle after reset is released.
- R3: A lower-byte write in cycle W loads the counter with {upper part, new lower byte}. It gives no `rx_tick` in cycle W, and the next pulse comes in cycle W+D+1, where D is the combined value.
- R4: An upper-part write alone leaves the running count alone. The new value takes effect at the next natural reload.
- R5: Asynchronous mode (`sync_mode`=0) with `dbl_speed`=0: `tx_tick` coincides with every 16th base pulse counted from reset.
- R6: Asynchronous mode with `dbl_speed`=1: `tx_tick` coincides with every 8th base pulse counted from reset.
- R7: Synchronous master mode (`sync_mode`=1, `clk_dir_out`=1): `tx_tick` coincides with every 2nd base pulse. `ser_clk_out` equals the parity of the base pulses seen since reset. In every other mode it is 0.
- R8: Synchronous slave mode (`sync_mode`=1, `clk_dir_out`=0) with `clk_pol`=0: a rising edge of `ext_clk_in` sampled at clock edge k gives a one-cycle `tx_tick` in the cycle after edge k+1.
- R9: Slave mode with `clk_pol`=1: the same timing as R8, but on falling edges of `ext_clk_in`. Rising edges give no tick.
- R10: In slave mode base pulses produce no `tx_tick`. `rx_tick` keeps running at the base rate.
- R11: In asynchronous mode `clk_dir_out`, `clk_pol` and `ext_clk_in` have no effect on `tx_tick` or `ser_clk_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| div_hi_wr | input | 1 | Upper-part divisor write strobe |
| div_hi_data | input | 4 | Upper part of the divisor |
| div_lo_wr | input | 1 | Lower-byte write strobe; restarts the counter |
| div_lo_data | input | 8 | Lower byte of the divisor |
| sync_mode | input | 1 | 1 = synchronous, 0 = asynchronous |
| dbl_speed | input | 1 | Asynchronous double speed (/8 instead of /16) |
| clk_dir_out | input | 1 | Synchronous only: 1 = drive the clock (master), 0 = follow the external clock |
| clk_pol | input | 1 | Slave edge select: 0 = rising, 1 = falling |
| ext_clk_in | input | 1 | External serial clock, asynchronous to `clk` |
| ser_clk_out | output | 1 | Serial clock driven in master mode |
| tx_tick | output | 1 | One-cycle transmit bit strobe |
| rx_tick | output | 1 | One-cycle receive base strobe |

## Verification
The bench aims at restart timing. It writes the lower byte in the middle of a count and back to back with divisor 0. A design that missed the restart, or let a tick slip out in the write cycle, would drift by one or more cycles against the model. It stages an upper part without a lower write, which catches a design that reloads early and shortens the next period. It also runs the slave path in both polarities with irregular edge spacing and changes modes in mid-run. That exposes a synchroniser with the wrong depth, a swapped polarity, a divider phase that resets on a mode change, or base pulses that leak into slave transmit timing.

// File: rtl/usart_clkgen_pkg.sv
// Package: shared mode encoding for the serial clock generator.
package usart_clkgen_pkg;
    typedef enum logic [1:0] {
        CM_ASYNC_NORM  = 2'd0,
        CM_ASYNC_DBL   = 2'd1,
        CM_SYNC_MASTER = 2'd2,
        CM_SYNC_SLAVE  = 2'd3
    } clk_mode_e;
endpackage

// File: rtl/usart_baud_counter.sv
// Module: usart_baud_counter
// Holds the split divisor and runs a reload down-counter that emits one base
// strobe per divisor+1 cycles. A lower-byte write restarts the count with the
// staged upper part and the new lower byte.
// Assumes: hi and lo writes are not issued in the same cycle (if they are,
// the restart value uses the previous upper part).
module usart_baud_counter #(
    parameter int HI_W = 4,
    parameter int LO_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            hi_wr,
    input  logic [HI_W-1:0] hi_data,
    input  logic            lo_wr,
    input  logic [LO_W-1:0] lo_data,
    output logic            base_tick
);
    localparam int DIV_W = HI_W + LO_W;

    logic [DIV_W-1:0] div_q;
    logic [DIV_W-1:0] cnt_q;
    logic [DIV_W-1:0] restart_val;

    assign restart_val = {div_q[DIV_W-1:LO_W], lo_data};

    // Divisor storage: each half is captured on its own strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_q <= '0;
        end else begin
            if (hi_wr) div_q[DIV_W-1:LO_W] <= hi_data;
            if (lo_wr) div_q[LO_W-1:0]     <= lo_data;
        end
    end

    // Down-counter: restart on lower write, reload at zero, otherwise decrement.
    always_ff @(posedge clk) begin
        if (!rst_n)             cnt_q <= '0;
        else if (lo_wr)         cnt_q <= restart_val;
        else if (cnt_q == '0)   cnt_q <= div_q;
        else                    cnt_q <= cnt_q - 1'b1;
    end

    // Base strobe: counter at zero and not being restarted this cycle.
    assign base_tick = rst_n & ~lo_wr & (cnt_q == '0);

    p_count_down_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!lo_wr && cnt_q != '0) |=> cnt_q == $past(cnt_q) - 1'b1);

    p_reload_at_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!lo_wr && cnt_q == '0) |=> cnt_q == $past(div_q));

    p_lo_write_restart_r3: assert property (@(posedge clk) disable iff (!rst_n)
        lo_wr |=> cnt_q == {$past(div_q[DIV_W-1:LO_W]), $past(lo_data)});
endmodule

// File: rtl/usart_tx_divider.sv
// Module: usart_tx_divider
// Free-running /2, /4, /2 chain advanced by the base strobe. It gives the /2,
// /8 and /16 strobes and the level of the first stage (for the clock output).
// Assumes: base_tick is a one-cycle strobe; stages never restart except on reset.
module usart_tx_divider #(
    parameter int MID_W = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic base_tick,
    output logic half_lvl,
    output logic tick_div2,
    output logic tick_div8,
    output logic tick_div16
);
    localparam logic [MID_W-1:0] MID_LAST = '1;

    logic             first_q;
    logic [MID_W-1:0] mid_q;
    logic             last_q;

    assign tick_div2  = base_tick & first_q;
    assign tick_div8  = tick_div2 & (mid_q == MID_LAST);
    assign tick_div16 = tick_div8 & last_q;
    assign half_lvl   = first_q;

    // First /2 stage: toggles on every base strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)         first_q <= 1'b0;
        else if (base_tick) first_q <= ~first_q;
    end

    // Middle /4 stage: counts /2 strobes.
    always_ff @(posedge clk) begin
        if (!rst_n)         mid_q <= '0;
        else if (tick_div2) mid_q <= mid_q + 1'b1;
    end

    // Last /2 stage: toggles on every /8 strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)         last_q <= 1'b0;
        else if (tick_div8) last_q <= ~last_q;
    end

    p_first_toggles_r7: assert property (@(posedge clk) disable iff (!rst_n)
        base_tick |=> first_q != $past(first_q));

    p_mid_holds_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_div2 |=> $stable(mid_q));
endmodule

// File: rtl/usart_ext_clk_sync.sv
// Module: usart_ext_clk_sync
// Brings an asynchronous external clock into the system clock domain through a
// flip-flop chain, then flags the chosen edge for one cycle.
// Assumes: external clock high and low phases each last over STAGES+1 cycles.
module usart_ext_clk_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ext_clk,
    input  logic fall_sel,
    output logic edge_tick
);
    logic [STAGES-1:0] sync_q;
    logic              prev_q;
    logic              cur;

    assign cur = sync_q[STAGES-1];

    // Synchroniser chain plus the edge-history flop.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= '0;
            prev_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[STAGES-2:0], ext_clk};
            prev_q <= cur;
        end
    end

    // Edge select: rising when fall_sel is 0, falling when 1.
    assign edge_tick = fall_sel ? (prev_q & ~cur) : (cur & ~prev_q);

    p_edge_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        edge_tick ##1 $stable(fall_sel) |-> !edge_tick);
endmodule

// File: rtl/usart_clkgen.sv
// Module: usart_clkgen (top)
// Baud and bit-clock generator: the base strobe feeds the receiver directly.
// The transmit strobe is picked by mode from the divider chain or the
// synchronised external clock.
// Assumes: mode inputs are quasi-static; changes take effect in the same cycle.
module usart_clkgen
    import usart_clkgen_pkg::*;
#(
    parameter int HI_W        = 4,
    parameter int LO_W        = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            div_hi_wr,
    input  logic [HI_W-1:0] div_hi_data,
    input  logic            div_lo_wr,
    input  logic [LO_W-1:0] div_lo_data,
    input  logic            sync_mode,
    input  logic            dbl_speed,
    input  logic            clk_dir_out,
    input  logic            clk_pol,
    input  logic            ext_clk_in,
    output logic            ser_clk_out,
    output logic            tx_tick,
    output logic            rx_tick
);
    clk_mode_e mode;
    logic      base_tick;
    logic      half_lvl;
    logic      t2, t8, t16;
    logic      ext_tick;

    // Mode decode: the direction bit only matters in synchronous mode.
    always_comb begin
        if (!sync_mode) mode = dbl_speed ? CM_ASYNC_DBL : CM_ASYNC_NORM;
        else            mode = clk_dir_out ? CM_SYNC_MASTER : CM_SYNC_SLAVE;
    end

    usart_baud_counter #(.HI_W(HI_W), .LO_W(LO_W)) i_cnt (
        .clk(clk), .rst_n(rst_n),
        .hi_wr(div_hi_wr), .hi_data(div_hi_data),
        .lo_wr(div_lo_wr), .lo_data(div_lo_data),
        .base_tick(base_tick)
    );

    usart_tx_divider #(.MID_W(2)) i_div (
        .clk(clk), .rst_n(rst_n), .base_tick(base_tick),
        .half_lvl(half_lvl), .tick_div2(t2), .tick_div8(t8), .tick_div16(t16)
    );

    usart_ext_clk_sync #(.STAGES(SYNC_STAGES)) i_sync (
        .clk(clk), .rst_n(rst_n), .ext_clk(ext_clk_in),
        .fall_sel(clk_pol), .edge_tick(ext_tick)
    );

    // Transmit strobe source selection by mode.
    always_comb begin
        unique case (mode)
            CM_ASYNC_NORM:  tx_tick = t16;
            CM_ASYNC_DBL:   tx_tick = t8;
            CM_SYNC_MASTER: tx_tick = t2;
            default:        tx_tick = ext_tick;
        endcase
    end

    assign rx_tick     = base_tick;
    assign ser_clk_out = (mode == CM_SYNC_MASTER) ? half_lvl : 1'b0;

    p_tx_on_base_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mode != CM_SYNC_SLAVE && tx_tick) |-> rx_tick);

    p_master_clk_moves_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == CM_SYNC_MASTER && rx_tick) ##1 (mode == CM_SYNC_MASTER)
            |-> ser_clk_out != $past(ser_clk_out));
endmodule

// File: tb/test_usart_clkgen.sv
module test_usart_clkgen;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       div_hi_wr = 1'b0;
    logic [3:0] div_hi_data = '0;
    logic       div_lo_wr = 1'b0;
    logic [7:0] div_lo_data = '0;
    logic       sync_mode = 1'b0, dbl_speed = 1'b0, clk_dir_out = 1'b0, clk_pol = 1'b0;
    logic       ext_clk_in = 1'b0;
    logic       ser_clk_out, tx_tick, rx_tick;

    int    total = 0, bad = 0, cycles = 0;
    string cur_req = "R1";

    // reference model state
    int m_cnt = 0, m_div = 0, m_n = 0;
    bit h0 = 0, h1 = 0, h2 = 0;

    always #4 clk = ~clk;

    usart_clkgen i_usart_clkgen (
        .clk(clk), .rst_n(rst_n),
        .div_hi_wr(div_hi_wr), .div_hi_data(div_hi_data),
        .div_lo_wr(div_lo_wr), .div_lo_data(div_lo_data),
        .sync_mode(sync_mode), .dbl_speed(dbl_speed),
        .clk_dir_out(clk_dir_out), .clk_pol(clk_pol),
        .ext_clk_in(ext_clk_in), .ser_clk_out(ser_clk_out),
        .tx_tick(tx_tick), .rx_tick(rx_tick)
    );

    task automatic check(input string what, input logic act, input logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s at cycle %0d: actual=%b expected=%b",
                     cur_req, what, cycles, act, exp);
        end
    endtask

    // Reference update at each clock edge (inputs are stable here).
    always @(posedge clk) begin
        cycles++;
        if (!rst_n) begin
            m_cnt = 0; m_div = 0; m_n = 0; h0 = 0; h1 = 0; h2 = 0;
        end else begin
            if (m_cnt == 0 && !div_lo_wr) m_n++;
            if (div_lo_wr)       m_cnt = (m_div & 'hF00) | int'(div_lo_data);
            else if (m_cnt == 0) m_cnt = m_div;
            else                 m_cnt--;
            if (div_hi_wr) m_div = (m_div & 'hFF) | (int'(div_hi_data) << 8);
            if (div_lo_wr) m_div = (m_div & 'hF00) | int'(div_lo_data);
            h2 = h1; h1 = h0; h0 = ext_clk_in;
        end
    end

    // Compare every cycle, mid-period.
    always @(negedge clk) begin
        bit base_e, tx_e, ser_e, master, slave;
        int k;
        base_e = rst_n && m_cnt == 0 && !div_lo_wr;
        master = sync_mode && clk_dir_out;
        slave  = sync_mode && !clk_dir_out;
        k = master ? 2 : (dbl_speed ? 8 : 16);
        if (slave) tx_e = clk_pol ? (!h1 && h2) : (h1 && !h2);
        else       tx_e = base_e && ((m_n + 1) % k == 0);
        ser_e = master ? (m_n % 2 == 1) : 1'b0;
        check("rx_tick", rx_tick, base_e);
        check("tx_tick", tx_tick, tx_e);
        check("ser_clk_out", ser_clk_out, ser_e);
    end

    task automatic step(input int n);
        repeat (n) begin @(posedge clk); #2; end
    endtask

    task automatic wr_lo(input logic [7:0] v);
        div_lo_wr = 1'b1; div_lo_data = v; step(1); div_lo_wr = 1'b0;
    endtask

    task automatic wr_hi(input logic [3:0] v);
        div_hi_wr = 1'b1; div_hi_data = v; step(1); div_hi_wr = 1'b0;
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (100000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired: actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        cur_req = "R1"; step(4); rst_n = 1'b1;
        cur_req = "R2"; step(20);
        cur_req = "R3"; wr_lo(8'd3); step(2); wr_lo(8'd3);
        cur_req = "R5"; step(200);
        cur_req = "R6"; dbl_speed = 1'b1; step(150);
        cur_req = "R7"; sync_mode = 1'b1; clk_dir_out = 1'b1; step(60);
        cur_req = "R4"; wr_hi(4'd1); step(600);
        cur_req = "R3"; wr_hi(4'd0); step(7); wr_lo(8'd5); step(3); wr_lo(8'd5); step(30);
        wr_lo(8'd0); wr_lo(8'd0); wr_lo(8'd2); step(1); wr_lo(8'd0); step(40);
        cur_req = "R8"; clk_dir_out = 1'b0; clk_pol = 1'b0;
        for (int i = 0; i < 24; i++) begin ext_clk_in = ~ext_clk_in; step(3 + i % 5); end
        cur_req = "R9"; clk_pol = 1'b1;
        for (int i = 0; i < 24; i++) begin ext_clk_in = ~ext_clk_in; step(4 + i % 3); end
        cur_req = "R10"; ext_clk_in = 1'b0; wr_lo(8'd1); step(80);
        cur_req = "R11"; sync_mode = 1'b0; dbl_speed = 1'b0;
        for (int i = 0; i < 20; i++) begin
            ext_clk_in = ~ext_clk_in; clk_pol = i[0]; clk_dir_out = i[1]; step(5);
        end
        cur_req = "R6"; dbl_speed = 1'b1; step(60);
        cur_req = "R1"; rst_n = 1'b0; step(3);
        rst_n = 1'b1; cur_req = "R2"; step(10);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule